// File: doc/BRIEF.md
# Smart Card Bit-Period Timer

This block generates the bit timing for a half-duplex smart card serial link. Timing is built in two stages. A baud divider counts enabled card-clock cycles and emits one sampling tick per divisor period. A bit counter then groups a programmable number of those ticks into one elementary time unit (etu). The number of card clocks per etu is the product of the two settings. Out of reset, this product is 31 × 12 = 372, which matches the default clock-rate factor of the ISO 7816-3 link. Software is advised to keep the ticks-per-bit figure near 16 so that the receiver samples with better margin.

A receiver pulses the resync input when it detects a start edge. This clears both counters, so the next etu begins on that edge. The divisor and ticks-per-bit inputs are copied into working registers only at an etu boundary or on resync, so a bit that is in progress always completes with the timing it started with. There are three outputs, each a single-cycle registered strobe: the sampling tick, a mid-bit strobe for data sampling, and an end-of-bit strobe.

Top module: `etu_timer`

## Requirements
- R1: While rst is high all three strobes are low. After reset the working divisor is 31 and the ticks-per-bit figure is 12, whatever the register inputs hold, so the first etu ends on the 372nd enabled card clock.
- R2: samp_tick is high for one cycle, in the clock cycle after every Nth enabled edge. N is the 16-bit divisor {div_hi, div_lo} with div_lo as the low byte, and a divisor of 0 acts as 1.
- R3: On an edge where clk_en is low, no counter advances and, in the following cycle, none of the three strobes is high.
- R4: etu_end is high in the cycle after the Bth sampling tick of a bit period, where B is base and 0 acts as 1. It coincides with samp_tick, and the tick count then restarts from zero.
- R5: mid_strobe is high together with samp_tick for tick number max(1, B/2) of each bit period, with the division rounding down. When B is 1 (or 0), mid_strobe and etu_end are high in the same cycle.
- R6: A change on div_hi, div_lo or base made during a bit period does not alter that period. The new values are used from the first card clock after the next etu boundary.
- R7: An edge with resync high clears both counters and loads the register inputs. It suppresses all three strobes in the following cycle, even when that edge would have ended an etu. The next etu is timed from this edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | One-cycle enable per card clock period |
| resync | input | 1 | Clears the etu phase on a detected start edge |
| div_hi | input | DIV_W/2 | Divisor high byte |
| div_lo | input | DIV_W/2 | Divisor low byte |
| base | input | BASE_W | Sampling ticks per etu |
| samp_tick | output | 1 | Registered sampling tick strobe |
| mid_strobe | output | 1 | Registered mid-bit strobe |
| etu_end | output | 1 | Registered end-of-etu strobe |

## Verification
Two functions can land on the same edge. The first is a resync against the natural end of an etu. The bench provokes this directly: it counts enabled edges and raises resync on exactly the edge whose count would complete the bit. It then expects silent strobes followed by a full-length etu, timed with the values loaded at the resync. The second is the mid-bit sample against the end of the bit when ticks-per-bit is 0 or 1. The bench expects both strobes in the same cycle on every Nth enabled edge. Random runs add more of both cases through sparse resync pulses and small ticks-per-bit values.

// File: rtl/etu_pkg.sv
package etu_pkg;

  localparam int unsigned ETU_DIV_W_DEF    = 16;
  localparam int unsigned ETU_BASE_W_DEF   = 8;
  localparam int unsigned ETU_RST_DIV_DEF  = 31;
  localparam int unsigned ETU_RST_BASE_DEF = 12;

  // registered output strobes
  typedef struct packed {
    logic tick;
    logic mid;
    logic last;
  } etu_evt_t;

endpackage

// File: rtl/etu_cfg_shadow.sv
// Working copy of divisor and ticks-per-bit; loaded only on etu boundary or resync.
module etu_cfg_shadow #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned BASE_W   = 8,
  parameter int unsigned RST_DIV  = 31,
  parameter int unsigned RST_BASE = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [BASE_W-1:0] base_in,
  output logic [DIV_W-1:0]  div_eff,
  output logic [BASE_W-1:0] base_eff,
  output logic [BASE_W-1:0] mid_pt
);

  localparam logic [DIV_W-1:0]  DIV_ONE    = DIV_W'(1);
  localparam logic [BASE_W-1:0] BASE_ONE   = BASE_W'(1);
  localparam logic [DIV_W-1:0]  RST_DIV_V  = (RST_DIV == 0) ? DIV_ONE : DIV_W'(RST_DIV);
  localparam logic [BASE_W-1:0] RST_BASE_V = (RST_BASE == 0) ? BASE_ONE : BASE_W'(RST_BASE);
  localparam logic [BASE_W-1:0] RST_MID_V  = ((RST_BASE_V >> 1) == '0) ? BASE_ONE : (RST_BASE_V >> 1);

  logic [DIV_W-1:0]  div_nxt;
  logic [BASE_W-1:0] base_nxt;
  logic [BASE_W-1:0] mid_nxt;

  // zero settings are clamped once, at load time, to keep the counter compare shallow
  always_comb begin
    div_nxt  = (div_in == '0) ? DIV_ONE : div_in;
    base_nxt = (base_in == '0) ? BASE_ONE : base_in;
    mid_nxt  = ((base_nxt >> 1) == '0) ? BASE_ONE : (base_nxt >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_eff  <= RST_DIV_V;
      base_eff <= RST_BASE_V;
      mid_pt   <= RST_MID_V;
    end else if (load) begin
      div_eff  <= div_nxt;
      base_eff <= base_nxt;
      mid_pt   <= mid_nxt;
    end
  end

endmodule

// File: rtl/etu_baud_div.sv
// First stage: one sampling tick per div_eff enabled card clocks.
module etu_baud_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_eff,
  output logic             tick,
  output logic [DIV_W-1:0] cnt_o
);

  logic [DIV_W-1:0] cnt;
  logic             at_top;

  assign at_top = (cnt == (div_eff - DIV_W'(1)));
  assign tick   = clk_en & ~clr & at_top;
  assign cnt_o  = cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (clk_en) begin
      cnt <= at_top ? '0 : (cnt + DIV_W'(1));
    end
  end

endmodule

// File: rtl/etu_bit_cnt.sv
// Second stage: groups sampling ticks into one etu and flags mid and last tick.
module etu_bit_cnt #(
  parameter int unsigned BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic [BASE_W-1:0] base_eff,
  input  logic [BASE_W-1:0] mid_pt,
  output logic              at_mid,
  output logic              at_end
);

  logic [BASE_W-1:0] cnt;
  logic [BASE_W-1:0] nxt;

  assign nxt    = cnt + BASE_W'(1);
  assign at_mid = tick & (nxt == mid_pt);
  assign at_end = tick & (nxt == base_eff);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= at_end ? '0 : nxt;
    end
  end

endmodule

// File: rtl/etu_timer.sv
module etu_timer
  import etu_pkg::*;
#(
  parameter int unsigned DIV_W    = ETU_DIV_W_DEF,
  parameter int unsigned BASE_W   = ETU_BASE_W_DEF,
  parameter int unsigned RST_DIV  = ETU_RST_DIV_DEF,
  parameter int unsigned RST_BASE = ETU_RST_BASE_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en,
  input  logic                 resync,
  input  logic [DIV_W/2-1:0]   div_hi,
  input  logic [DIV_W/2-1:0]   div_lo,
  input  logic [BASE_W-1:0]    base,
  output logic                 samp_tick,
  output logic                 mid_strobe,
  output logic                 etu_end
);

  localparam int unsigned LATCH_W = DIV_W / 2;

  logic [DIV_W-1:0]  div_word;
  logic [DIV_W-1:0]  div_eff;
  logic [DIV_W-1:0]  div_cnt;
  logic [BASE_W-1:0] base_eff;
  logic [BASE_W-1:0] mid_pt;
  logic              tick_raw;
  logic              at_mid;
  logic              at_end;
  logic              load;
  etu_evt_t          evt_q;

  assign div_word = {div_hi[LATCH_W-1:0], div_lo[LATCH_W-1:0]};
  assign load     = resync | at_end;

  etu_cfg_shadow #(
    .DIV_W   (DIV_W),
    .BASE_W  (BASE_W),
    .RST_DIV (RST_DIV),
    .RST_BASE(RST_BASE)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .div_in  (div_word),
    .base_in (base),
    .div_eff (div_eff),
    .base_eff(base_eff),
    .mid_pt  (mid_pt)
  );

  etu_baud_div #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .clr    (resync),
    .div_eff(div_eff),
    .tick   (tick_raw),
    .cnt_o  (div_cnt)
  );

  etu_bit_cnt #(
    .BASE_W(BASE_W)
  ) u_bit (
    .clk     (clk),
    .rst     (rst),
    .clr     (resync),
    .tick    (tick_raw),
    .base_eff(base_eff),
    .mid_pt  (mid_pt),
    .at_mid  (at_mid),
    .at_end  (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      evt_q.tick <= tick_raw;
      evt_q.mid  <= at_mid;
      evt_q.last <= at_end;
    end
  end

  assign samp_tick  = evt_q.tick;
  assign mid_strobe = evt_q.mid;
  assign etu_end    = evt_q.last;

endmodule

// File: rtl/etu_timer_chk.sv
module etu_timer_chk #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned BASE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              resync,
  input logic              samp_tick,
  input logic              mid_strobe,
  input logic              etu_end,
  input logic              tick_raw,
  input logic              load,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [DIV_W-1:0]  div_eff,
  input logic [BASE_W-1:0] base_eff
);

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    div_cnt < div_eff);

  a_r3_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !samp_tick && !mid_strobe && !etu_end);

  a_r4_end_on_tick: assert property (@(posedge clk) disable iff (rst)
    etu_end |-> samp_tick);

  a_r5_mid_on_tick: assert property (@(posedge clk) disable iff (rst)
    mid_strobe |-> samp_tick);

  a_r5_single_tick_bit: assert property (@(posedge clk) disable iff (rst)
    (tick_raw && base_eff == BASE_W'(1)) |=> mid_strobe && etu_end);

  a_r6_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(div_eff) && $stable(base_eff));

  a_r7_resync_quiet: assert property (@(posedge clk) disable iff (rst)
    resync |=> !samp_tick && !mid_strobe && !etu_end);

endmodule

bind etu_timer etu_timer_chk #(
  .DIV_W (DIV_W),
  .BASE_W(BASE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en    (clk_en),
  .resync    (resync),
  .samp_tick (samp_tick),
  .mid_strobe(mid_strobe),
  .etu_end   (etu_end),
  .tick_raw  (tick_raw),
  .load      (load),
  .div_cnt   (div_cnt),
  .div_eff   (div_eff),
  .base_eff  (base_eff)
);

// File: tb/etu_timer_tb.sv
module etu_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic       resync = 1'b0;
  logic [7:0] div_hi = 8'd0;
  logic [7:0] div_lo = 8'd0;
  logic [7:0] base = 8'd0;
  logic       samp_tick;
  logic       mid_strobe;
  logic       etu_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  etu_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .resync    (resync),
    .div_hi    (div_hi),
    .div_lo    (div_lo),
    .base      (base),
    .samp_tick (samp_tick),
    .mid_strobe(mid_strobe),
    .etu_end   (etu_end)
  );

  int    checks = 0;
  int    fails = 0;
  int    cur_n = 31;
  int    cur_b = 12;
  int    cur_m = 6;
  int    cnt = 0;
  string end_tag = "R4";
  bit    done = 1'b0;

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int half(int b);
    return (b / 2 == 0) ? 1 : b / 2;
  endfunction

  task automatic load_cur();
    cur_n = eff(int'({div_hi, div_lo}));
    cur_b = eff(int'(base));
    cur_m = half(cur_b);
  endtask

  task automatic set_regs(int d, int b);
    {div_hi, div_lo} = 16'(d);
    base = 8'(b);
  endtask

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (count %0d)", tag, what, act, exp, cnt);
    end
  endtask

  // drive one edge, then judge the registered strobes half a period later
  task automatic step(input bit en, input bit rs, output bit ended);
    bit et, em, ee;
    clk_en = en;
    resync = rs;
    @(negedge clk);
    ended = 1'b0;
    if (rs) begin
      cnt = 0;
      load_cur();
      check("R7", samp_tick, 1'b0, "samp_tick after resync");
      check("R7", mid_strobe, 1'b0, "mid_strobe after resync");
      check("R7", etu_end, 1'b0, "etu_end after resync");
    end else if (en) begin
      cnt++;
      et = (cnt % cur_n) == 0;
      em = (cnt == cur_n * cur_m);
      ee = (cnt == cur_n * cur_b);
      check("R2", samp_tick, et, "samp_tick");
      check("R5", mid_strobe, em, "mid_strobe");
      check(end_tag, etu_end, ee, "etu_end");
      if (ee) begin
        cnt = 0;
        load_cur();
        ended = 1'b1;
      end
    end else begin
      check("R3", samp_tick, 1'b0, "samp_tick while idle");
      check("R3", mid_strobe, 1'b0, "mid_strobe while idle");
      check("R3", etu_end, 1'b0, "etu_end while idle");
    end
  endtask

  task automatic run_to_end(input bit gaps);
    bit e;
    e = 1'b0;
    for (int i = 0; i < 20000 && !e; i++) begin
      step(gaps ? ($urandom % 3 != 0) : 1'b1, 1'b0, e);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit e;
    void'($urandom(32'd7816));

    // R1: quiet in reset, reset divisor/base ignore the register inputs
    set_regs(5, 16);
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", samp_tick, 1'b0, "samp_tick in reset");
      check("R1", mid_strobe, 1'b0, "mid_strobe in reset");
      check("R1", etu_end, 1'b0, "etu_end in reset");
    end
    rst = 1'b0;
    cur_n = 31; cur_b = 12; cur_m = 6; cnt = 0;
    end_tag = "R1";
    run_to_end(1'b0);
    end_tag = "R4";
    run_to_end(1'b0);

    // R3: sparse card clock enables
    run_to_end(1'b1);

    // R6: change settings in mid bit, the running period keeps old values
    set_regs(7, 9);
    run_to_end(1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, e);
    set_regs(2, 3);
    end_tag = "R6";
    run_to_end(1'b1);
    end_tag = "R4";
    run_to_end(1'b0);

    // R7: resync on the very edge that would end an etu
    set_regs(3, 5);
    run_to_end(1'b0);
    while (cnt != cur_n * cur_b - 1) step(1'b1, 1'b0, e);
    set_regs(4, 6);
    step(1'b1, 1'b1, e);
    run_to_end(1'b0);

    // R2 R4 R5: zero divisor and zero base clamp to one
    set_regs(0, 0);
    run_to_end(1'b0);
    for (int i = 0; i < 20; i++) step($urandom % 2 == 1, 1'b0, e);

    // R5: one tick per bit, mid and end coincide
    set_regs(4, 1);
    run_to_end(1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, e);

    // R5: two ticks per bit, mid on first tick
    set_regs(3, 2);
    run_to_end(1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, e);

    // random mix
    for (int i = 0; i < 40000; i++) begin
      if ($urandom % 200 == 0) set_regs(int'($urandom % 13), int'($urandom % 21));
      step($urandom % 4 != 0, $urandom % 300 == 0, e);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule